// File: doc/BRIEF.md
# PRBS-7 Word Generator and Checker

This block supplies a built-in pattern test for a serial link that moves data in 10-bit word slots. While the test enable is high, the transmit word bound for the serializer is replaced by successive 10-bit pieces of a 127-bit pseudorandom sequence. The sequence follows the recurrence b[n] = b[n-6] xor b[n-7], which is the polynomial x^7 + x^6 + 1. The caller's own transmit word is ignored during this time. While the enable is low, the caller's word passes through unchanged and the generator keeps its position in the sequence.

The receive half checks an incoming stream of 10-bit words against the same recurrence and drives one pass level. It synchronizes itself from the received data, so it needs no shared seed. It takes the first seven bits received after enable as history, then predicts every later bit from the seven bits received just before it. When the transmit word is looped back to the receive word, the two halves together form a self-test whose result is the pass level.

Top module: `prbs7_bist`

## Requirements
- R1: While `prbs_en` is low, `tx_word_out` equals `tx_word_in` in the same cycle (combinational path).
- R2: While `prbs_en` is high, `tx_word_out` carries the sequence defined by b[n] = b[n-6] xor b[n-7]. Each word holds 10 consecutive sequence bits, and the earliest bit is in bit 0. `tx_word_in` has no effect on it. After reset the seven-bit history is all ones, so the first generated bit is 0.
- R3: While `prbs_en` is low, the generator does not advance. The first word after re-enabling is the word that would have followed the last word generated before the pause.
- R4: `prbs_ok` is low during reset, and it is low in every cycle that follows a clock edge at which `prbs_en` was low.
- R5: The word captured at the first enabled edge only loads the checker's history: bits 0 to 6 seed it and bits 7 to 9 are checked against it. `prbs_ok` stays low after that edge. It can first go high after the next edge, and only if that next word is fully consistent.
- R6: A captured word with any bit that differs from the value predicted by the seven previously received bits drives `prbs_ok` low after that edge.
- R7: Prediction always uses the received bits, including wrong ones. After an error, `prbs_ok` returns high after the first word whose ten bits all match their prediction. A single flipped bit can therefore keep it low for one word or for two words.
- R8: With `tx_word_out` looped to `rx_word_in` and the enable held high, `prbs_ok` stays high from the second enabled word onward.
- R9: The generated bit stream repeats with period 127: bit n equals bit n-127 for every n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| prbs_en | input | 1 | Test enable: selects the pattern at transmit and runs the checker |
| tx_word_in | input | 10 | Encoded word from the normal transmit path |
| tx_word_out | output | 10 | Word handed to the serializer |
| rx_word_in | input | 10 | Word from the deserializer |
| prbs_ok | output | 1 | High while received pattern words are error-free |

## Verification
A generator state that is wrong or has slipped shows on `tx_word_out` as soon as the next word is produced, because every word is compared bit for bit against a sequence the bench builds independently. The same comparison across a disable gap reveals a generator that advanced while it should have held. A checker whose history or synchronization flag is wrong shows on `prbs_ok` one edge after the affected word. It can appear as a pass on the loading word, as a missed drop on a corrupted word, or as a level that stays low after clean words.

// File: rtl/prbs7_pkg.sv
package prbs7_pkg;

    localparam int HIST_W = 7;

    typedef logic [HIST_W-1:0] hist_t;

    typedef enum logic {
        CK_IDLE = 1'b0,
        CK_RUN  = 1'b1
    } ck_mode_e;

    // predicted next bit: b[n] = b[n-6] ^ b[n-7]; h[0] is the newest bit
    function automatic logic next_bit(hist_t h);
        return h[5] ^ h[6];
    endfunction

    function automatic hist_t shift_in(hist_t h, logic b);
        return {h[HIST_W-2:0], b};
    endfunction

endpackage

// File: rtl/prbs7_gen.sv
module prbs7_gen
    import prbs7_pkg::*;
#(
    parameter int    WORD_W = 10,
    parameter hist_t SEED   = 7'h7F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    output logic [WORD_W-1:0] word
);

    hist_t state_q;
    hist_t state_d;

    always_comb begin
        hist_t h;
        logic  b;
        h    = state_q;
        word = '0;
        for (int i = 0; i < WORD_W; i++) begin
            b       = next_bit(h);
            word[i] = b;
            h       = shift_in(h, b);
        end
        state_d = h;
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= SEED;
        else if (run)
            state_q <= state_d;
    end

    // R3: disabled generator keeps its place
    assert_gen_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(state_q));

    // R9: a nonzero state keeps the maximal-length cycle
    assert_gen_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

endmodule

// File: rtl/prbs7_chk.sv
module prbs7_chk
    import prbs7_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [WORD_W-1:0] rx_word,
    output logic              ok
);

    ck_mode_e mode_q;
    hist_t    hist_q;
    hist_t    hist_d;
    logic     miss;

    always_comb begin
        hist_t h;
        h    = hist_q;
        miss = 1'b0;
        for (int i = 0; i < WORD_W; i++) begin
            if (mode_q == CK_RUN || i >= HIST_W)
                miss = miss | (rx_word[i] != next_bit(h));
            h = shift_in(h, rx_word[i]);
        end
        hist_d = h;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= CK_IDLE;
            hist_q <= '0;
            ok     <= 1'b0;
        end else if (!run) begin
            mode_q <= CK_IDLE;
            ok     <= 1'b0;
        end else begin
            mode_q <= CK_RUN;
            hist_q <= hist_d;
            ok     <= (mode_q == CK_RUN) && !miss;
        end
    end

    // R4: no pass indication after a disabled edge
    assert_ok_low_off_R4: assert property (@(posedge clk) disable iff (rst)
        !run |=> !ok);

    // R5: the loading word never yields a pass
    assert_load_word_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |=> !ok);

    // R5: a pass implies the checker is synchronized
    assert_ok_synced_R5: assert property (@(posedge clk) disable iff (rst)
        ok |-> mode_q == CK_RUN);

endmodule

// File: rtl/prbs7_bist.sv
module prbs7_bist
    import prbs7_pkg::*;
#(
    parameter int    WORD_W = 10,
    parameter hist_t SEED   = 7'h7F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prbs_en,
    input  logic [WORD_W-1:0] tx_word_in,
    output logic [WORD_W-1:0] tx_word_out,
    input  logic [WORD_W-1:0] rx_word_in,
    output logic              prbs_ok
);

    logic [WORD_W-1:0] pat_word;

    prbs7_gen #(.WORD_W(WORD_W), .SEED(SEED)) u_gen (
        .clk  (clk),
        .rst  (rst),
        .run  (prbs_en),
        .word (pat_word)
    );

    prbs7_chk #(.WORD_W(WORD_W)) u_chk (
        .clk     (clk),
        .rst     (rst),
        .run     (prbs_en),
        .rx_word (rx_word_in),
        .ok      (prbs_ok)
    );

    assign tx_word_out = prbs_en ? pat_word : tx_word_in;

    // R4: reset leaves the pass level low on the following edge
    assert_ok_after_reset_R4: assert property (@(posedge clk)
        rst |=> !prbs_ok);

endmodule

// File: tb/prbs7_bist_test.sv
module prbs7_bist_test;

    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en  = 1'b0;
    logic [W-1:0] txi = '0;
    logic [W-1:0] rxi = '0;
    logic [W-1:0] txo;
    logic         ok;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [6:0] g_hist = 7'h7F;
    logic [6:0] m_hist = '0;
    bit         m_run  = 0;
    bit         exp_q[$];
    string      tag_q[$];
    bit         seq[$];

    always #4 clk = ~clk;

    prbs7_bist uut (
        .clk         (clk),
        .rst         (rst),
        .prbs_en     (en),
        .tx_word_in  (txi),
        .tx_word_out (txo),
        .rx_word_in  (rxi),
        .prbs_ok     (ok)
    );

    task automatic cmp(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference sequence, R2: b[n] = b[n-6] ^ b[n-7], earliest bit at bit 0
    function automatic logic [W-1:0] ref_word();
        logic [W-1:0] w;
        for (int i = 0; i < W; i++) begin
            w[i]   = g_hist[5] ^ g_hist[6];
            g_hist = {g_hist[5:0], w[i]};
        end
        return w;
    endfunction

    // expected pass level per R4..R7
    function automatic bit model_ok(logic e, logic [W-1:0] w);
        bit clean;
        bit r;
        if (!e) begin
            m_run = 0;
            return 0;
        end
        clean = 1;
        for (int i = 0; i < W; i++) begin
            if ((m_run || i >= 7) && w[i] != (m_hist[5] ^ m_hist[6]))
                clean = 0;
            m_hist = {m_hist[5:0], w[i]};
        end
        r     = m_run && clean;
        m_run = 1;
        return r;
    endfunction

    task automatic drive(logic e, logic [W-1:0] tin, logic [W-1:0] flip, string req);
        logic [W-1:0] want;
        @(negedge clk);
        en  = e;
        txi = tin;
        #1;
        if (e) begin
            want = ref_word();
            cmp("R2 tx pattern", 32'(txo), 32'(want));
            for (int i = 0; i < W; i++) seq.push_back(want[i]);
            rxi = txo ^ flip;
        end else begin
            cmp("R1 bypass", 32'(txo), 32'(tin));
            rxi = tin;
        end
        exp_q.push_back(model_ok(e, rxi));
        tag_q.push_back(req);
    endtask

    // monitor: compares each registered pass level with its queued expectation
    always @(posedge clk) begin
        #2;
        if (!rst && exp_q.size() > 0) begin
            bit    w;
            string t;
            w = exp_q.pop_front();
            t = tag_q.pop_front();
            cmp(t, 32'(ok), 32'(w));
        end
    end

    initial begin
        #100000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        txi = 10'h3C5;
        repeat (3) @(posedge clk);
        #2;
        cmp("R4 reset ok", 32'(ok), 32'd0);
        cmp("R1 reset bypass", 32'(txo), 32'h3C5);
        @(negedge clk);
        rst = 1'b0;

        drive(0, 10'h2A5, '0, "R4 disabled");
        drive(0, 10'h15A, '0, "R4 disabled");

        drive(1, 10'h3FF, '0, "R5 loading word");
        drive(1, 10'h000, '0, "R5 first pass");
        for (int i = 0; i < 140; i++)
            drive(1, W'($urandom), '0, "R8 loopback");

        begin
            int errs = 0;
            for (int n = 127; n < seq.size(); n++)
                if (seq[n] != seq[n-127]) errs++;
            cmp("R9 period 127", 32'(errs), 32'd0);
        end

        for (int i = 0; i < 3; i++)
            drive(0, W'($urandom), '0, "R3 paused");
        drive(1, 10'h155, '0, "R3 resume load");
        for (int i = 0; i < 10; i++)
            drive(1, W'($urandom), '0, "R3 resumed");

        drive(1, 10'h0F0, 10'h004, "R6 error bit2");
        drive(1, 10'h0F0, '0,      "R7 recover");
        drive(1, 10'h0F0, '0,      "R7 steady");
        drive(1, 10'h0F0, 10'h200, "R6 error bit9");
        drive(1, 10'h0F0, '0,      "R7 after bit9");
        drive(1, 10'h0F0, '0,      "R7 recovered");
        drive(0, 10'h0AA, '0,      "R4 disable");

        repeat (3) @(posedge clk);
        #3;
        cmp("R4 final low", 32'(ok), 32'd0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule